// File: doc/BRIEF.md
# Oversampling serial receiver with two-word buffer

The block receives asynchronous serial characters on a single input line and hands them to a processor through a small register port. A programmable divisor, together with a speed select, sets a 16x oversample tick. From that tick a receive state machine finds the falling edge of a start bit and confirms it at mid-bit. It then decides each data bit and the stop bit by a two-of-three vote of samples taken around the bit centre. Characters are 8 bits, or 9 bits when the wide mode is chosen.

Each finished character is stored with its own ninth bit and framing result in a two-entry buffer. Software reads the status register first, to get the ninth bit and the framing result of the oldest entry. It then reads the data register, which returns the low eight bits and removes the entry. If a character completes while both entries are still unread, a sticky overrun flag is raised. While that flag stands, every further character is dropped. Only turning off the continuous-receive enable clears the flag.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the status register (address 2) reads 0, and `rx_done_o`, `irq_o`, `ferr_o` and `oerr_o` are 0.
- R2: Characters are received only while control (address 0) has bit0 (port enable) = 1, bit1 (synchronous select) = 0 and bit2 (continuous receive) = 1. With any other setting a complete frame on `rx_i` leaves the buffer empty.
- R3: One bit lasts 16·(N+1) clocks when control bit4 (high speed) = 1, and 64·(N+1) clocks when it is 0, where N is the divisor register (address 1).
- R4: Data arrive LSB first after a low start bit. Reading the data register (address 3) returns the low eight data bits and removes the oldest entry.
- R5: With control bit3 (wide mode) = 1, nine data bits are received, and the ninth is shown in status bit0 for the oldest entry. With bit3 = 0, status bit0 reads 0.
- R6: Status bit3 and `rx_done_o` are 1 while the buffer holds at least one entry. `irq_o` is `rx_done_o` gated by control bit5 (interrupt enable).
- R7: The buffer holds two characters, which are read back in arrival order.
- R8: A character that completes while two entries are unread sets the overrun flag (status bit2, `oerr_o`). That character and every later one are discarded while the flag is set.
- R9: The overrun flag stays set through data reads and clears only when control bit2 is written 0.
- R10: A character whose stop bit votes low has status bit1 and `ferr_o` set while it is the oldest entry. The flag belongs to that entry only.
- R11: A low pulse on `rx_i` that is high again by mid-bit is rejected as a false start and stores nothing.
- R12: A one-clock inversion of a data bit near its centre does not change the received value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (a read of address 3 removes the oldest entry) |
| addr_i | input | 2 | Register address: 0 control, 1 divisor, 2 status, 3 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rx_done_o | output | 1 | Buffer not empty |
| irq_o | output | 1 | Receive interrupt |
| ferr_o | output | 1 | Framing error of the oldest entry |
| oerr_o | output | 1 | Sticky overrun |

## Verification
The hardest state to reach is overrun followed by recovery. The bench sends three characters back to back without reading any of them. It then drains the two stored entries to confirm that the third character was lost and that the flag survives the reads. A fourth frame is sent while the flag is set, to show it is dropped. The continuous-receive enable is then cycled, and one more frame proves that reception works again. False-start rejection and the bit vote are reached by shaping `rx_i` with sub-bit pulses that are timed against the oversample grid.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CTL_EN   = 0;
  localparam int CTL_SYNC = 1;
  localparam int CTL_CONT = 2;
  localparam int CTL_NINE = 3;
  localparam int CTL_HS   = 4;
  localparam int CTL_IRQ  = 5;
  localparam int CTL_W    = 6;

  typedef struct packed {
    logic [8:0] data;
    logic       ferr;
  } rx_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W    = 8,
  parameter int NORM_PRE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hs_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = DIV_W + $clog2(NORM_PRE) + 1;

  logic [CW-1:0] cnt_q, lim;

  // normal mode stretches each oversample period by NORM_PRE
  always_comb begin
    if (hs_i) lim = CW'(div_i);
    else      lim = CW'((CW'(div_i) + CW'(1)) * CW'(NORM_PRE) - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     nine_i,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int OW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  rx_state_e   state_q;
  logic [OW-1:0] os_q;
  logic [3:0]  bit_q;
  logic [8:0]  sh_q;
  logic [1:0]  smp_q;
  logic        vote;
  logic [3:0]  last_bit;

  assign vote     = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_i) | (smp_q[0] & rx_i);
  assign last_bit = nine_i ? 4'd8 : 4'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      smp_q   <= '0;
      done_o  <= 1'b0;
      word_o  <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!rx_i) begin
            state_q <= ST_START;
            os_q    <= '0;
          end
        end else begin
          os_q <= (os_q == OW'(OSR - 1)) ? '0 : os_q + OW'(1);
          if (os_q == OW'(MID - 1)) smp_q[1] <= rx_i;
          if (os_q == OW'(MID))     smp_q[0] <= rx_i;
          if (os_q == OW'(MID + 1)) begin
            unique case (state_q)
              ST_START: if (vote) state_q <= ST_IDLE;
              ST_DATA:  sh_q <= {vote, sh_q[8:1]};
              ST_STOP: begin
                done_o      <= 1'b1;
                word_o.data <= nine_i ? sh_q : {1'b0, sh_q[8:1]};
                word_o.ferr <= ~vote;
                state_q     <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (os_q == OW'(OSR - 1)) begin
            if (state_q == ST_START) begin
              state_q <= ST_DATA;
              bit_q   <= '0;
            end else if (state_q == ST_DATA) begin
              bit_q <= bit_q + 4'd1;
              if (bit_q == last_bit) state_q <= ST_STOP;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  rx_word_t wdata_i,
  input  logic     pop_i,
  output rx_word_t head_o,
  output logic     empty_o,
  output logic     full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_word_t mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign head_o  = mem_q[rp_q];
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= wdata_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_W       = 8,
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rx_done_o,
  output logic          irq_o,
  output logic          ferr_o,
  output logic          oerr_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CTL_W-1:0] ctl_q;
  logic [DIV_W-1:0] div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic rx_s, rx_en, cont_rx, tick, word_done, oerr_q;
  logic fifo_empty, fifo_full, push, pop;
  logic [CNT_W-1:0] fifo_cnt;
  rx_word_t word, head;
  logic [7:0] stat;

  // line synchronizer, idles high
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= (g == 0) ? rx_i : sync_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      div_q <= '0;
    end else if (we_i) begin
      if (addr_i == 2'd0) ctl_q <= wdata_i[CTL_W-1:0];
      if (addr_i == 2'd1) div_q <= wdata_i[DIV_W-1:0];
    end
  end

  assign cont_rx = ctl_q[CTL_CONT];
  assign rx_en   = ctl_q[CTL_EN] & ~ctl_q[CTL_SYNC] & cont_rx;

  uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk_i, .rst_ni, .en_i(rx_en), .hs_i(ctl_q[CTL_HS]), .div_i(div_q), .tick_o(tick)
  );

  uart_rx_shift #(.OSR(OSR)) shift_i (
    .clk_i, .rst_ni, .en_i(rx_en), .tick_i(tick), .rx_i(rx_s),
    .nine_i(ctl_q[CTL_NINE]), .done_o(word_done), .word_o(word)
  );

  assign pop  = re_i & (addr_i == 2'd3) & ~fifo_empty;
  assign push = word_done & ~oerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                oerr_q <= 1'b0;
    else if (!cont_rx)                          oerr_q <= 1'b0;
    else if (word_done && fifo_full && !pop)    oerr_q <= 1'b1;
  end

  uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(word), .pop_i(pop),
    .head_o(head), .empty_o(fifo_empty), .full_o(fifo_full), .count_o(fifo_cnt)
  );

  assign stat = {4'd0, ~fifo_empty, oerr_q, head.ferr & ~fifo_empty, head.data[8] & ~fifo_empty};

  always_comb begin
    unique case (addr_i)
      2'd0:    rdata_o = DW'(ctl_q);
      2'd1:    rdata_o = DW'(div_q);
      2'd2:    rdata_o = DW'(stat);
      default: rdata_o = fifo_empty ? '0 : DW'(head.data[7:0]);
    endcase
  end

  assign rx_done_o = ~fifo_empty;
  assign irq_o     = ~fifo_empty & ctl_q[CTL_IRQ];
  assign ferr_o    = head.ferr & ~fifo_empty;
  assign oerr_o    = oerr_q;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DEPTH = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_done_o,
  input logic irq_o,
  input logic ferr_o,
  input logic oerr_o,
  input logic word_done,
  input logic fifo_full,
  input logic rx_en,
  input logic cont_rx,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  // R2
  done_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |-> $past(rx_en));
  // R6
  irq_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_done_o);
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));
  // R8
  oerr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oerr_o) |-> ($past(fifo_full) && $past(word_done)));
  // R9
  oerr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oerr_o) |-> !$past(cont_rx));
  // R10
  ferr_has_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |-> rx_done_o);
endmodule

bind uart_rx_core uart_rx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_done_o(rx_done_o), .irq_o(irq_o),
  .ferr_o(ferr_o), .oerr_o(oerr_o), .word_done(word_done), .fifo_full(fifo_full),
  .rx_en(rx_en), .cont_rx(cont_rx), .fifo_cnt(fifo_cnt)
);

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0, rx = 1'b1, we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rx_done, irq, ferr, oerr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_rx_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_done_o(rx_done), .irq_o(irq),
    .ferr_o(ferr), .oerr_o(oerr)
  );

  // {nine, hs, div[7:0], data[8:0], stop}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd0, 9'h0A5, 1'b1},
    {1'b0, 1'b1, 8'd1, 9'h03C, 1'b1},
    {1'b0, 1'b0, 8'd0, 9'h0F0, 1'b1},
    {1'b1, 1'b1, 8'd0, 9'h1C3, 1'b1},
    {1'b1, 1'b0, 8'd1, 9'h155, 1'b1},
    {1'b1, 1'b1, 8'd0, 9'h0AA, 1'b1},
    {1'b0, 1'b1, 8'd0, 9'h181, 1'b1},
    {1'b0, 1'b1, 8'd0, 9'h066, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit stop, input int t);
    int nb;
    nb = nine ? 9 : 8;
    @(negedge clk); rx = 1'b0;
    repeat (t) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = d[i];
      repeat (t) @(negedge clk);
    end
    rx = stop;
    repeat (t) @(negedge clk);
    rx = 1'b1;
    repeat (t) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    logic [8:0] exp_d;
    int t;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd2, s);
    chk("R1 status", s, 0);
    chk("R1 flags", {rx_done, irq, ferr, oerr}, 0);

    // table walk: R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      t = (VEC[v][18] ? 16 : 64) * (VEC[v][17:10] + 1);
      exp_d = VEC[v][19] ? VEC[v][9:1] : {1'b0, VEC[v][8:1]};
      wr(2'd1, VEC[v][17:10]);
      wr(2'd0, 8'h25 | (8'(VEC[v][19]) << 3) | (8'(VEC[v][18]) << 4));
      send(VEC[v][9:1], VEC[v][19], VEC[v][0], t);
      repeat (4) @(negedge clk);
      chk("R6 done", rx_done, 1);
      chk("R6 irq", irq, 1);
      chk("R10 ferr pin", ferr, !VEC[v][0]);
      rd(2'd2, s);
      chk("R5 ninth", s[0], exp_d[8]);
      chk("R10 ferr stat", s[1], !VEC[v][0]);
      rd(2'd3, d);
      chk("R3 R4 data", d, exp_d[7:0]);
      chk("R6 empty after read", rx_done, 0);
    end

    // R6 interrupt gated off
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h15);
    send(9'h012, 0, 1, 16);
    repeat (4) @(negedge clk);
    chk("R6 irq masked", {rx_done, irq}, 2'b10);
    rd(2'd3, d);
    chk("R4 data masked run", d, 8'h12);

    // R2 disabled settings
    wr(2'd0, 8'h17);  // sync select set
    send(9'h055, 0, 1, 16);
    repeat (4) @(negedge clk);
    chk("R2 sync blocks", rx_done, 0);
    wr(2'd0, 8'h14);  // port disabled
    send(9'h055, 0, 1, 16);
    repeat (4) @(negedge clk);
    chk("R2 port off blocks", rx_done, 0);

    // R11 false start
    wr(2'd0, 8'h35);
    @(negedge clk); rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (200) @(negedge clk);
    chk("R11 glitch rejected", rx_done, 0);

    // R12 single-clock inversion at bit centre (bit0 = 1, inverted briefly)
    @(negedge clk); rx = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = 1'b1;
      repeat (10) @(negedge clk);
      rx = 1'b0;
      @(negedge clk);
      rx = 1'b1;
      repeat (5) @(negedge clk);
    end
    rx = 1'b1;
    repeat (32) @(negedge clk);
    rd(2'd3, d);
    chk("R12 vote", d, 8'hFF);

    // R7 R8 R9 overrun
    send(9'h011, 0, 1, 16);
    send(9'h022, 0, 1, 16);
    chk("R8 no overrun at two", oerr, 0);
    send(9'h033, 0, 1, 16);
    repeat (4) @(negedge clk);
    chk("R8 overrun set", oerr, 1);
    rd(2'd2, s);
    chk("R8 status bit", s[2], 1);
    rd(2'd3, d);
    chk("R7 first", d, 8'h11);
    rd(2'd3, d);
    chk("R7 second", d, 8'h22);
    chk("R8 third dropped", rx_done, 0);
    chk("R9 survives reads", oerr, 1);
    send(9'h044, 0, 1, 16);
    repeat (4) @(negedge clk);
    chk("R8 blocked while set", rx_done, 0);
    wr(2'd0, 8'h31);
    @(negedge clk);
    chk("R9 cleared", oerr, 0);
    wr(2'd0, 8'h35);
    send(9'h077, 0, 1, 16);
    repeat (4) @(negedge clk);
    rd(2'd3, d);
    chk("R9 resumes", d, 8'h77);

    // R10 flag per entry
    send(9'h0A0, 0, 0, 16);
    send(9'h0B0, 0, 1, 16);
    repeat (4) @(negedge clk);
    chk("R10 first bad", ferr, 1);
    rd(2'd3, d);
    chk("R10 next good", ferr, 0);
    rd(2'd3, d);
    chk("R10 second data", d, 8'hB0);

    // R1 reset clears buffer and flags
    send(9'h0C0, 0, 1, 16);
    send(9'h0C1, 0, 1, 16);
    send(9'h0C2, 0, 1, 16);
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", {rx_done, irq, ferr, oerr}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule